// File: doc/BRIEF.md
# Micro-TLB with Lazy Invalidation

This block is a small, fully associative translation cache placed in front of a larger, low-associativity main TLB. A core keeps one instance for data accesses (8 ways) and one for instruction fetch (4 ways); both come from the same module with a different way-count parameter. Each way holds a copy of one main-TLB entry in flip-flops: a virtual page number, an address-space identifier, a physical frame number and a permission field.

A lookup presents a virtual page and an ASID and gets the frame and permissions back combinationally in the same cycle. On a miss the block raises a refill request that carries the page and ASID and holds it until the main TLB answers; the answer is written into a free way, or into the least recently used way when all are full. Entries are never dropped because the main TLB replaced its own copy: only an explicit invalidate, or a main-TLB write of the invalidating kind, clears the whole array. This lets the high associativity of the small cache hide conflict misses in the main TLB.

Top module: `utlb_top`

## Requirements
- R1: While `lkValid` is high and a valid way holds the same page and ASID, `lkHit` is 1 and `lkPfn`/`lkPerm` carry that way's stored values in the same cycle; at most one way matches.
- R2: The ASID is part of the tag: a lookup with a stored page but a different ASID misses.
- R3: A missing lookup while no refill is outstanding raises `refillReq` at the next clock edge with `refillVpn`/`refillAsid` equal to the looked-up page and ASID; these hold unchanged, despite further misses, until the refill is answered or cleared.
- R4: `fillValid` while `refillReq` is high writes the returned frame and permissions under the requested tag and drops `refillReq` at that edge; a later lookup hits. `fillValid` with no outstanding request is ignored.
- R5: A refill goes into the lowest-numbered empty way; when every way is full it replaces the way least recently hit or written.
- R6: `invAll` clears every entry at the next clock edge and withdraws an outstanding refill request.
- R7: A main-TLB write (`mainWrite`) with `mainWrKeep`=1 (victim replacement during miss handling) leaves all entries valid; with `mainWrKeep`=0 it clears every entry like `invAll`.
- R8: A clear arriving in the same cycle as `fillValid` wins: the array ends empty, the returned entry is discarded and `refillReq` falls.
- R9: After reset no entry is valid and `refillReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request this cycle |
| lkVpn | input | VPN_W | Lookup virtual page number |
| lkAsid | input | ASID_W | Lookup address-space identifier |
| lkHit | output | 1 | Lookup hit (combinational) |
| lkPfn | output | PFN_W | Frame of the matching way, 0 on miss |
| lkPerm | output | PERM_W | Permissions of the matching way, 0 on miss |
| refillReq | output | 1 | Refill outstanding towards the main TLB |
| refillVpn | output | VPN_W | Page of the outstanding refill |
| refillAsid | output | ASID_W | ASID of the outstanding refill |
| fillValid | input | 1 | Main TLB returns the refill data |
| fillPfn | input | PFN_W | Returned frame number |
| fillPerm | input | PERM_W | Returned permission bits |
| invAll | input | 1 | Invalidate all entries |
| mainWrite | input | 1 | A main-TLB entry is being written |
| mainWrKeep | input | 1 | With mainWrite: 1 keeps entries, 0 clears all |

## Verification
The bench builds the data-side variant, eight ways with 20-bit pages and frames, 8-bit ASIDs and 6 permission bits. Eight ways make it possible to fill the array completely, reorder recency with a hit and then see exactly which way the ninth refill displaces, which is the case that tells true LRU apart from round-robin or first-way replacement. The same width lets the ASID-mismatch, stray-fill, keep-write and clear-versus-fill races be driven on a populated array, so that a wrongly dropped or retained entry shows up as a wrong hit or miss at the lookup port.

// File: rtl/utlb_pkg.sv
`timescale 1ns/1ps
package utlb_pkg;
  // strobes from control to the entry array
  typedef struct packed {
    logic clearAll;
    logic install;
  } utlbStrb_t;
endpackage

// File: rtl/utlb_entries.sv
`timescale 1ns/1ps
module utlb_entries
  import utlb_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  utlbStrb_t         strb,
  input  logic [WAYS-1:0]   instWayOh,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [PERM_W-1:0] fillPerm,
  output logic [WAYS-1:0]   hitVec,
  output logic [WAYS-1:0]   validVec,
  output logic [PFN_W-1:0]  hitPfn,
  output logic [PERM_W-1:0] hitPerm
);
  logic [VPN_W-1:0]  tagVpn  [WAYS];
  logic [ASID_W-1:0] tagAsid [WAYS];
  logic [PFN_W-1:0]  datPfn  [WAYS];
  logic [PERM_W-1:0] datPerm [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[w] <= 1'b0;
        tagVpn[w]   <= '0;
        tagAsid[w]  <= '0;
        datPfn[w]   <= '0;
        datPerm[w]  <= '0;
      end else if (strb.clearAll) begin
        validVec[w] <= 1'b0;
      end else if (strb.install && instWayOh[w]) begin
        validVec[w] <= 1'b1;
        tagVpn[w]   <= fillVpn;
        tagAsid[w]  <= fillAsid;
        datPfn[w]   <= fillPfn;
        datPerm[w]  <= fillPerm;
      end
    end

    assign hitVec[w] = validVec[w] && (tagVpn[w] == lkVpn) && (tagAsid[w] == lkAsid);
  end

  // masked OR read mux: at most one way matches
  always_comb begin
    hitPfn  = '0;
    hitPerm = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitPfn  = hitPfn  | (datPfn[w]  & {PFN_W{hitVec[w]}});
      hitPerm = hitPerm | (datPerm[w] & {PERM_W{hitVec[w]}});
    end
  end
endmodule

// File: rtl/utlb_ctrl.sv
`timescale 1ns/1ps
module utlb_ctrl
  import utlb_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [WAYS-1:0]   hitVec,
  input  logic [WAYS-1:0]   validVec,
  input  logic              fillValid,
  input  logic              invAll,
  input  logic              mainWrite,
  input  logic              mainWrKeep,
  output utlbStrb_t         strb,
  output logic [WAYS-1:0]   instWayOh,
  output logic              refillReq,
  output logic [VPN_W-1:0]  refillVpn,
  output logic [ASID_W-1:0] refillAsid
);
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(WAYS - 1);

  logic [IDX_W-1:0] age [WAYS];   // 0 = most recent, WAYS-1 = least recent
  logic [IDX_W-1:0] victimIdx, hitIdx, touchIdx, refAge;
  logic             freeFound, anyHit, doClear, doInstall, touchHit, touchEn;

  assign anyHit    = |hitVec;
  assign doClear   = invAll | (mainWrite & ~mainWrKeep);
  assign doInstall = fillValid & refillReq & ~doClear;
  assign touchHit  = lkValid & anyHit & ~doClear & ~doInstall;
  assign touchEn   = doInstall | touchHit;

  // victim: lowest empty way, else the oldest one
  always_comb begin
    freeFound = 1'b0;
    victimIdx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeFound = 1'b1;
        victimIdx = IDX_W'(i);
      end
    end
    if (!freeFound) begin
      for (int i = 0; i < WAYS; i++) begin
        if (age[i] == OLDEST) victimIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign touchIdx = doInstall ? victimIdx : hitIdx;
  assign refAge   = age[touchIdx];

  always_comb begin
    instWayOh = '0;
    instWayOh[victimIdx] = doInstall;
  end

  assign strb.clearAll = doClear;
  assign strb.install  = doInstall;

  // recency ranks stay a permutation of 0..WAYS-1
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < WAYS; j++) age[j] <= IDX_W'(j);
    end else if (touchEn) begin
      for (int j = 0; j < WAYS; j++) begin
        if (IDX_W'(j) == touchIdx)  age[j] <= '0;
        else if (age[j] < refAge)   age[j] <= age[j] + 1'b1;
      end
    end
  end

  // single outstanding refill
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refillReq  <= 1'b0;
      refillVpn  <= '0;
      refillAsid <= '0;
    end else if (doClear || doInstall) begin
      refillReq  <= 1'b0;
    end else if (lkValid && !anyHit && !refillReq) begin
      refillReq  <= 1'b1;
      refillVpn  <= lkVpn;
      refillAsid <= lkAsid;
    end
  end
endmodule

// File: rtl/utlb_top.sv
`timescale 1ns/1ps
module utlb_top
  import utlb_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  output logic              lkHit,
  output logic [PFN_W-1:0]  lkPfn,
  output logic [PERM_W-1:0] lkPerm,
  output logic              refillReq,
  output logic [VPN_W-1:0]  refillVpn,
  output logic [ASID_W-1:0] refillAsid,
  input  logic              fillValid,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [PERM_W-1:0] fillPerm,
  input  logic              invAll,
  input  logic              mainWrite,
  input  logic              mainWrKeep
);
  utlbStrb_t       strb;
  logic [WAYS-1:0] hitVec, validVec, instWayOh;

  utlb_ctrl #(.WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkAsid(lkAsid),
    .hitVec(hitVec), .validVec(validVec), .fillValid(fillValid),
    .invAll(invAll), .mainWrite(mainWrite), .mainWrKeep(mainWrKeep),
    .strb(strb), .instWayOh(instWayOh), .refillReq(refillReq),
    .refillVpn(refillVpn), .refillAsid(refillAsid)
  );

  utlb_entries #(.WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W),
                 .PFN_W(PFN_W), .PERM_W(PERM_W)) u_ent (
    .clk(clk), .rstN(rstN), .strb(strb), .instWayOh(instWayOh),
    .lkVpn(lkVpn), .lkAsid(lkAsid), .fillVpn(refillVpn), .fillAsid(refillAsid),
    .fillPfn(fillPfn), .fillPerm(fillPerm), .hitVec(hitVec), .validVec(validVec),
    .hitPfn(lkPfn), .hitPerm(lkPerm)
  );

  assign lkHit = lkValid & (|hitVec);
endmodule

// File: rtl/utlb_checker.sv
`timescale 1ns/1ps
module utlb_checker #(
  parameter int WAYS   = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [WAYS-1:0]   hitVec,
  input logic [WAYS-1:0]   validVec,
  input logic [WAYS-1:0]   instWayOh,
  input logic              refillReq,
  input logic [VPN_W-1:0]  refillVpn,
  input logic [ASID_W-1:0] refillAsid,
  input logic              fillValid,
  input logic              invAll,
  input logic              mainWrite,
  input logic              mainWrKeep
);
  logic clearNow;
  assign clearNow = invAll | (mainWrite & ~mainWrKeep);

  a_r1_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  a_r3_request_held: assert property (@(posedge clk) disable iff (!rstN)
    (refillReq && !fillValid && !clearNow) |=>
      (refillReq && $stable(refillVpn) && $stable(refillAsid)));

  a_r4_stray_fill_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !refillReq && !clearNow) |=> $stable(validVec));

  a_r5_one_victim: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && refillReq && !clearNow) |-> ($countones(instWayOh) == 1));

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    clearNow |=> (validVec == '0 && !refillReq));

  a_r7_keep_write: assert property (@(posedge clk) disable iff (!rstN)
    (mainWrite && mainWrKeep && !invAll && !(fillValid && refillReq)) |=> $stable(validVec));

  a_r8_clear_beats_fill: assert property (@(posedge clk) disable iff (!rstN)
    (clearNow && fillValid && refillReq) |=> (validVec == '0));
endmodule

bind utlb_top utlb_checker #(.WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_chk (
  .clk(clk), .rstN(rstN), .hitVec(hitVec), .validVec(validVec),
  .instWayOh(instWayOh), .refillReq(refillReq), .refillVpn(refillVpn),
  .refillAsid(refillAsid), .fillValid(fillValid), .invAll(invAll),
  .mainWrite(mainWrite), .mainWrKeep(mainWrKeep)
);

// File: tb/sim_utlb_top.sv
`timescale 1ns/1ps
module sim_utlb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic [19:0] lkVpn = '0;
  logic [7:0]  lkAsid = '0;
  logic        lkHit;
  logic [19:0] lkPfn;
  logic [5:0]  lkPerm;
  logic        refillReq;
  logic [19:0] refillVpn;
  logic [7:0]  refillAsid;
  logic        fillValid = 1'b0;
  logic [19:0] fillPfn = '0;
  logic [5:0]  fillPerm = '0;
  logic        invAll = 1'b0;
  logic        mainWrite = 1'b0;
  logic        mainWrKeep = 1'b0;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  utlb_top #(.WAYS(8), .VPN_W(20), .ASID_W(8), .PFN_W(20), .PERM_W(6)) u0 (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkAsid(lkAsid),
    .lkHit(lkHit), .lkPfn(lkPfn), .lkPerm(lkPerm), .refillReq(refillReq),
    .refillVpn(refillVpn), .refillAsid(refillAsid), .fillValid(fillValid),
    .fillPfn(fillPfn), .fillPerm(fillPerm), .invAll(invAll),
    .mainWrite(mainWrite), .mainWrKeep(mainWrKeep)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic look(input logic [19:0] v, input logic [7:0] a,
                      output logic h, output logic [19:0] p, output logic [5:0] pm);
    lkVpn = v; lkAsid = a; lkValid = 1'b1;
    #2;
    h = lkHit; p = lkPfn; pm = lkPerm;
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  task automatic refill(input logic [19:0] v, input logic [7:0] a,
                        input logic [19:0] p, input logic [5:0] pm);
    logic h; logic [19:0] rp; logic [5:0] rpm;
    look(v, a, h, rp, rpm);
    chk("R3 refill miss", h, 0);
    chk("R3 request raised", refillReq, 1);
    chk("R3 request page", refillVpn, v);
    chk("R3 request asid", refillAsid, a);
    fillPfn = p; fillPerm = pm; fillValid = 1'b1;
    @(negedge clk);
    fillValid = 1'b0;
    chk("R4 request dropped", refillReq, 0);
  endtask

  task automatic expectHit(input string tag, input logic [19:0] v, input logic [7:0] a,
                           input logic [19:0] p, input logic [5:0] pm);
    logic h; logic [19:0] rp; logic [5:0] rpm;
    look(v, a, h, rp, rpm);
    chk(tag, {h, rp, rpm}, {1'b1, p, pm});
  endtask

  task automatic expectMiss(input string tag, input logic [19:0] v, input logic [7:0] a);
    logic h; logic [19:0] rp; logic [5:0] rpm;
    look(v, a, h, rp, rpm);
    chk(tag, h, 0);
  endtask

  task automatic flushAll();
    invAll = 1'b1;
    @(negedge clk);
    invAll = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 no request after reset", refillReq, 0);
    lkVpn = 20'h00123; lkAsid = 8'h01; lkValid = 1'b1;
    #2;
    chk("R9 empty after reset", lkHit, 0);
    lkValid = 1'b0;
    #2;
  endtask

  task automatic t_basic();
    refill(20'h00A10, 8'h05, 20'hBEEF1, 6'h2D);
    expectHit("R1 hit data", 20'h00A10, 8'h05, 20'hBEEF1, 6'h2D);
    refill(20'h00A11, 8'h05, 20'h12345, 6'h12);
    expectHit("R4 second entry", 20'h00A11, 8'h05, 20'h12345, 6'h12);
    expectHit("R1 first entry kept", 20'h00A10, 8'h05, 20'hBEEF1, 6'h2D);
    flushAll();
  endtask

  task automatic t_asid();
    refill(20'h00B00, 8'h07, 20'h0B0B0, 6'h3F);
    expectMiss("R2 other asid misses", 20'h00B00, 8'h08);
    chk("R2 request asid", refillAsid, 8'h08);
    expectHit("R2 own asid hits", 20'h00B00, 8'h07, 20'h0B0B0, 6'h3F);
    flushAll();
  endtask

  task automatic t_hold();
    expectMiss("R3 first miss", 20'h00C01, 8'h01);
    expectMiss("R3 second miss", 20'h00C02, 8'h02);
    chk("R3 page held", refillVpn, 20'h00C01);
    chk("R3 asid held", refillAsid, 8'h01);
    chk("R3 still pending", refillReq, 1);
    flushAll();
    chk("R6 clear drops request", refillReq, 0);
  endtask

  task automatic t_stray();
    refill(20'h00D00, 8'h03, 20'h0D0D0, 6'h01);
    fillPfn = 20'hFFFFF; fillPerm = 6'h3F; fillValid = 1'b1;
    @(negedge clk);
    fillValid = 1'b0;
    chk("R4 stray fill no request", refillReq, 0);
    expectHit("R4 stray fill ignored", 20'h00D00, 8'h03, 20'h0D0D0, 6'h01);
    flushAll();
  endtask

  task automatic t_lru();
    for (int i = 0; i < 8; i++)
      refill(20'h01000 + 20'(i), 8'h02, 20'h20000 + 20'(i), 6'(i));
    for (int i = 0; i < 8; i++)
      expectHit("R5 all eight resident", 20'h01000 + 20'(i), 8'h02, 20'h20000 + 20'(i), 6'(i));
    // recency now 0 (oldest) .. 7; make page 0 most recent so page 1 is the LRU
    expectHit("R5 touch page 0", 20'h01000, 8'h02, 20'h20000, 6'd0);
    refill(20'h01008, 8'h02, 20'h20008, 6'd8);
    expectMiss("R5 LRU page evicted", 20'h01001, 8'h02);
    chk("R5 miss request page", refillVpn, 20'h01001);
    expectHit("R5 touched page kept", 20'h01000, 8'h02, 20'h20000, 6'd0);
    expectHit("R5 new page present", 20'h01008, 8'h02, 20'h20008, 6'd8);
    expectHit("R5 next page kept", 20'h01002, 8'h02, 20'h20002, 6'd2);
    flushAll();
    for (int i = 0; i < 8; i++)
      expectMiss("R6 all cleared", 20'h01000 + 20'(i), 8'h02);
    flushAll();
  endtask

  task automatic t_mainWrite();
    refill(20'h00E00, 8'h09, 20'h0E0E0, 6'h15);
    mainWrite = 1'b1; mainWrKeep = 1'b1;
    @(negedge clk);
    mainWrite = 1'b0;
    expectHit("R7 keep write leaves entry", 20'h00E00, 8'h09, 20'h0E0E0, 6'h15);
    mainWrite = 1'b1; mainWrKeep = 1'b0;
    @(negedge clk);
    mainWrite = 1'b0;
    expectMiss("R7 invalidating write clears", 20'h00E00, 8'h09);
    flushAll();
  endtask

  task automatic t_race();
    refill(20'h00F00, 8'h04, 20'h0F0F0, 6'h0A);
    expectMiss("R8 miss before race", 20'h00F01, 8'h04);
    chk("R8 request before race", refillReq, 1);
    fillPfn = 20'h0F0F1; fillPerm = 6'h0B; fillValid = 1'b1; invAll = 1'b1;
    @(negedge clk);
    fillValid = 1'b0; invAll = 1'b0;
    chk("R8 request dropped by clear", refillReq, 0);
    expectMiss("R8 refill discarded", 20'h00F01, 8'h04);
    expectMiss("R8 older entry cleared", 20'h00F00, 8'h04);
    flushAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_basic();
    t_asid();
    t_hold();
    t_stray();
    t_lru();
    t_mainWrite();
    t_race();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule